// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a 32-bit interval timer that a processor controls through a small word-addressed register port. Software writes a start count into a load register and picks a rate, a mode and an enable in a control register. While it is enabled, the timer decrements its count at the chosen rate. It reports expiry on a level interrupt line. Two count rates are derived internally by dividing the system clock, and the two division ratios are parameters. The count can be read at any time. Writing the load register replaces the live count at once, even while the timer is counting.

In one-shot mode the timer stops at zero and stays there until software writes a new count. In periodic mode it takes the load value again on the tick after reaching zero and keeps running, so each period lasts the load value plus one ticks. The interrupt stays high until software writes anything to the clear address.

A three-state machine sequences the counter:
- **IDLE**: the timer is disabled. It goes to RUN when enable is set.
- **RUN**: the timer counts ticks. It goes back to IDLE when enable is cleared. In one-shot mode it goes to HOLD on expiry.
- **HOLD**: the one-shot timer has expired and its count stays at zero. It goes to IDLE when enable is cleared.

A load write moves the machine from any state to RUN if enable is set, or to IDLE if it is not.

Top module: `tmr_down_timer`

## Requirements
- R1: After reset the load value, the count, the control word and the interrupt are all zero, and the timer is idle.
- R2: Register word index 0 (byte offset 0x0) reads and writes the load value. Index 1 (0x4) reads the live count, and writes to it are ignored. Index 2 (0x8) is the control word. Index 3 (0xC) is the interrupt clear and always reads zero.
- R3: A write to the load register sets the count on the next clock edge, even while the timer is counting or disabled. It also restarts the rate divider.
- R4: In the control word, bit 7 enables counting, bit 6 selects periodic mode (1) or one-shot mode (0), and bit 3 selects the fast rate (1) or the slow rate (0). All other bits read as zero.
- R5: While the timer is running, the count decrements once every SLOW_DIV or FAST_DIV clocks, depending on the selected rate. The first decrement comes that many clocks after the load write.
- R6: The interrupt rises on the same edge at which the count steps from 1 to 0.
- R7: In periodic mode, a tick at count zero reloads the load value without raising the interrupt, which gives a period of (load+1) ticks. A load of 0 therefore never interrupts.
- R8: In one-shot mode the count holds at zero after expiry and stops, until the next load write. A one-shot timer loaded with 0 expires on its first tick.
- R9: A write of any data to the clear index drops the interrupt on the next edge. If an expiry falls on the same edge, the interrupt stays high.
- R10: Clearing the enable bit freezes the count at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 2 | Register word index (byte offset / 4) |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word, combinational |
| irq | output | 1 | Level interrupt, high after expiry until cleared |

## Verification
Read data is combinational, so a register value appears in the same cycle the index is applied. A load write that takes effect at edge E0 shows its count right after E0. The k-th decrement lands at edge E0 + k*DIV, and the interrupt rises at E0 + N*DIV. A clear or a control write acts on the edge that samples it. Inputs change on falling edges and results are sampled just after the falling edge that follows each rising edge. The bench sweeps every start count from 0 to 6 over both rates and both modes. It compares the count and the interrupt after every edge against the floor(t/DIV) tick arithmetic. It also times one clear write so that it lands exactly on an expiry edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic en;
        logic periodic;
        logic fast;
    } tmr_ctrl_t;

    localparam logic [1:0] IDX_LOAD  = 2'd0;
    localparam logic [1:0] IDX_VALUE = 2'd1;
    localparam logic [1:0] IDX_CTRL  = 2'd2;
    localparam logic [1:0] IDX_CLEAR = 2'd3;

    localparam int BIT_EN       = 7;
    localparam int BIT_PERIODIC = 6;
    localparam int BIT_FAST     = 3;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SLOW_DIV = 25000,
    parameter int FAST_DIV = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic fast,
    output logic tick
);
    localparam int MAXD  = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PRE_W = (MAXD > 2) ? $clog2(MAXD) : 1;
    localparam logic [PRE_W-1:0] SLOW_TOP = PRE_W'(SLOW_DIV - 1);
    localparam logic [PRE_W-1:0] FAST_TOP = PRE_W'(FAST_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] top;

    assign top  = fast ? FAST_TOP : SLOW_TOP;
    assign tick = run && (pre_q == top);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || restart) begin
            pre_q <= '0;
        end else if (pre_q == top) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R5: phase counter never passes the selected terminal value
    a_r5_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= top);

    // R5: with a divider above one, ticks are never back to back
    a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && top != '0 && !restart) |=> !tick);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_word,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] load_q,
    output tmr_ctrl_t         ctrl_q,
    output logic              wr_load,
    output logic              wr_ctrl,
    output logic              wr_clr
);
    logic [DATA_W-1:0] ctrl_word;

    assign wr_load = bus_we && (bus_word == IDX_LOAD);
    assign wr_ctrl = bus_we && (bus_word == IDX_CTRL);
    assign wr_clr  = bus_we && (bus_word == IDX_CLEAR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_load) begin
                load_q <= bus_wdata;
            end
            if (wr_ctrl) begin
                ctrl_q.en       <= bus_wdata[BIT_EN];
                ctrl_q.periodic <= bus_wdata[BIT_PERIODIC];
                ctrl_q.fast     <= bus_wdata[BIT_FAST];
            end
        end
    end

    always_comb begin
        ctrl_word               = '0;
        ctrl_word[BIT_EN]       = ctrl_q.en;
        ctrl_word[BIT_PERIODIC] = ctrl_q.periodic;
        ctrl_word[BIT_FAST]     = ctrl_q.fast;
    end

    always_comb begin
        unique case (bus_word)
            IDX_LOAD:  bus_rdata = load_q;
            IDX_VALUE: bus_rdata = count;
            IDX_CTRL:  bus_rdata = ctrl_word;
            default:   bus_rdata = '0;
        endcase
    end

    // R3: load register captures the written word
    a_r3_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (load_q == $past(bus_wdata)));

    // R2: clear index reads as zero
    a_r2_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word == IDX_CLEAR) |-> (bus_rdata == '0));

endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  tmr_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] reload,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              wr_clr,
    output logic [DATA_W-1:0] count_q,
    output logic              irq_q,
    output logic              running
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    tmr_state_e        state_q, state_d;
    logic [DATA_W-1:0] count_d;
    logic              expire;

    assign running = (state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        expire  = 1'b0;
        if (wr_load) begin
            count_d = load_data;
            state_d = ctrl.en ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ctrl.en) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (!ctrl.en) begin
                        state_d = ST_IDLE;
                    end else if (tick) begin
                        if (count_q == '0) begin
                            if (ctrl.periodic) begin
                                count_d = reload;
                            end else begin
                                expire  = 1'b1;
                                state_d = ST_HOLD;
                            end
                        end else begin
                            count_d = count_q - ONE;
                            if (count_q == ONE) begin
                                expire = 1'b1;
                                if (!ctrl.periodic) state_d = ST_HOLD;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (!ctrl.en) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (expire) begin
            irq_q <= 1'b1;
        end else if (wr_clr) begin
            irq_q <= 1'b0;
        end
    end

    a_r3_load_now: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (count_q == $past(load_data)));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctrl.en && tick && !wr_load && count_q != '0)
        |=> (count_q == $past(count_q) - ONE));

    a_r6_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> (count_q == '0));

    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctrl.en && ctrl.periodic && tick && !wr_load && count_q == '0)
        |=> (count_q == $past(reload)));

    a_r8_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !wr_load) |=> $stable(count_q));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !expire) |=> !irq_q);

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_load) |=> $stable(count_q));

endmodule

// File: rtl/tmr_down_timer.sv
module tmr_down_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SLOW_DIV = 25000,
    parameter int FAST_DIV = 98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_word,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] count_q;
    tmr_ctrl_t         ctrl_q;
    logic              wr_load, wr_ctrl, wr_clr;
    logic              tick, running;

    tmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_word  (bus_word),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .count     (count_q),
        .bus_rdata (bus_rdata),
        .load_q    (load_q),
        .ctrl_q    (ctrl_q),
        .wr_load   (wr_load),
        .wr_ctrl   (wr_ctrl),
        .wr_clr    (wr_clr)
    );

    tmr_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (wr_load || wr_ctrl),
        .fast    (ctrl_q.fast),
        .tick    (tick)
    );

    tmr_count_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ctrl      (ctrl_q),
        .reload    (load_q),
        .wr_load   (wr_load),
        .load_data (bus_wdata),
        .wr_clr    (wr_clr),
        .count_q   (count_q),
        .irq_q     (irq),
        .running   (running)
    );

endmodule

// File: tb/test_tmr_down_timer.sv
module test_tmr_down_timer;
    localparam int CLK_PERIOD = 10;
    localparam int SDIV = 5;
    localparam int FDIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_down_timer #(.DATA_W(32), .SLOW_DIV(SDIV), .FAST_DIV(FDIV)) i_tmr_down_timer (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; write lands on the next rising edge
    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        bus_word = w; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cw(input bit en, input bit per, input bit fast);
        logic [31:0] c;
        c = '0; c[7] = en; c[6] = per; c[3] = fast;
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, frozen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 load", v, 0);
        rd(2'd1, v); check("R1 value", v, 0);
        rd(2'd2, v); check("R1 ctrl", v, 0);
        check("R1 irq", {31'd0, irq}, 0);
        @(negedge clk);

        // R4 control bit mask
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R4 ctrl mask", v, 32'h0000_00C8);
        wr(2'd2, 32'h0);
        rd(2'd2, v); check("R4 ctrl zero", v, 0);

        // R3 load while disabled, R2 value write ignored, clear reads zero
        wr(2'd0, 32'd7);
        rd(2'd1, v); check("R3 load disabled", v, 7);
        wr(2'd1, 32'h55);
        rd(2'd1, v); check("R2 value write ignored", v, 7);
        rd(2'd0, v); check("R2 load readback", v, 7);
        rd(2'd3, v); check("R2 clear reads zero", v, 0);
        @(negedge clk);

        // R5 R6 R7 R8 sweep
        for (int per = 0; per < 2; per++) begin
            for (int fs = 0; fs < 2; fs++) begin
                for (int n = 0; n <= 6; n++) begin
                    int div;
                    div = fs ? FDIV : SDIV;
                    wr(2'd2, 32'h0);
                    wr(2'd3, 32'h0);
                    wr(2'd2, cw(1'b1, per[0], fs[0]));
                    wr(2'd0, n);
                    bus_word = 2'd1;
                    for (int t = 1; t <= (2*n + 3) * div; t++) begin
                        int k;
                        logic [31:0] ec;
                        logic ei;
                        @(negedge clk);
                        #1;
                        k = t / div;
                        if (per == 1) begin
                            ec = n - (k % (n + 1));
                            ei = (n > 0) && (k >= n);
                        end else begin
                            ec = (k >= n) ? 0 : n - k;
                            ei = (k >= ((n > 0) ? n : 1));
                        end
                        if (per == 1) begin
                            check("R5 R7 periodic value", bus_rdata, ec);
                            check("R6 R7 periodic irq", {31'd0, irq}, {31'd0, ei});
                        end else begin
                            check("R5 R8 one-shot value", bus_rdata, ec);
                            check("R6 R8 one-shot irq", {31'd0, irq}, {31'd0, ei});
                        end
                    end
                    if (per == 0) begin
                        wr(2'd3, 32'hDEAD_BEEF);
                        check("R9 clear", {31'd0, irq}, 0);
                        repeat (3 * div) @(negedge clk);
                        rd(2'd1, v); check("R8 held after clear", v, 0);
                        check("R9 stays clear", {31'd0, irq}, 0);
                    end
                    @(negedge clk);
                end
            end
        end

        // R9 clear landing on an expiry edge: periodic fast N=2, expiries at E4, E10
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
        wr(2'd2, cw(1'b1, 1'b1, 1'b1));
        wr(2'd0, 32'd2);
        repeat (9) @(negedge clk);
        wr(2'd3, 32'h1);
        #1;
        check("R9 expiry beats clear", {31'd0, irq}, 1);
        wr(2'd3, 32'h1);
        #1;
        check("R9 clear off expiry", {31'd0, irq}, 0);

        // R10 disable freezes: periodic fast N=5, ctrl write lands at E4 -> count 3
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
        wr(2'd2, cw(1'b1, 1'b1, 1'b1));
        wr(2'd0, 32'd5);
        repeat (3) @(negedge clk);
        wr(2'd2, cw(1'b0, 1'b1, 1'b1));
        rd(2'd1, frozen);
        check("R10 frozen value", frozen, 3);
        repeat (20) @(negedge clk);
        rd(2'd1, v); check("R10 still frozen", v, 3);
        check("R10 no irq", {31'd0, irq}, 0);

        // R3 reload while running: one-shot slow N=6, overwrite with 2 at E13
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
        wr(2'd2, cw(1'b1, 1'b0, 1'b0));
        wr(2'd0, 32'd6);
        repeat (12) @(negedge clk);
        wr(2'd0, 32'd2);
        rd(2'd1, v); check("R3 live reload", v, 2);
        for (int t = 1; t <= 10; t++) begin
            @(negedge clk);
            #1;
            check("R3 restarted count", bus_rdata, (t >= 10) ? 0 : 2 - t / SDIV);
            check("R3 restarted irq", {31'd0, irq}, (t >= 10) ? 1 : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule